// File: doc/BRIEF.md
# Processor crash dump capture

This block keeps a snapshot of the processor's state at the moment a qualifying reset is requested. Four 32-bit words come in from the processor all the time: the program counter of the instruction now executing, the program counter it would have gone to next, the last data address it used and the address of the last exception. When the capture enable is set and either a hardware-request reset or a debug-module reset starts, all four words are stored at once. The stored record is held in flops that only power-on reset clears. The reset that caused the capture therefore leaves it intact, and software can examine it afterwards.

Software sets the enable bit and a 2-bit word selector through one small control register. It reads the selected stored word through a single 32-bit read-only window. The capture trigger is edge-sensitive. A reset request held high for many cycles stores the inputs of its first cycle only.

Top module: `crash_snap`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `ctl_rdata` is 0 and the stored record reads zero at every selector value.
- R2: A cycle with `ctl_we` high loads `ctl_wdata` into the control register, and it shows on `ctl_rdata` after that clock edge. Bit 0 is the capture enable and bits 2:1 are the word selector.
- R3: `rd_data` returns the stored word chosen by the selector in the same cycle. The mapping is 3 = current PC, 2 = next PC, 1 = last data address and 0 = exception address.
- R4: Suppose the enable stored in the control register is 1 at a clock edge where `hw_rst_req` is high and was low at the previous edge (or this is the first edge after power-on reset). Then all four dump inputs sampled at that edge are stored.
- R5: The same rising-edge rule as R4 applies to `dbg_rst_req`. If both requests rise together, one capture results.
- R6: Neither request changes the stored record while the stored enable is 0.
- R7: Suppose a request stays high across later clock edges and the other request does not rise. Then no further capture happens, even if the dump inputs change.
- R8: The stored record keeps its value through any number of cycles without a qualifying edge, and through control register writes. This includes clearing the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control write data: bit 0 enable, bits 2:1 selector |
| ctl_rdata | output | 3 | Control register contents |
| hw_rst_req | input | 1 | Hardware-request reset request |
| dbg_rst_req | input | 1 | Debug-module reset request |
| dump_cur_pc | input | 32 | Processor current program counter |
| dump_next_pc | input | 32 | Processor next program counter |
| dump_last_daddr | input | 32 | Processor last data address |
| dump_exc_addr | input | 32 | Processor exception address |
| rd_data | output | 32 | Stored word chosen by the selector |

## Verification
The bench holds a reset request high for several cycles while the dump inputs keep changing. A design that captures on level rather than edge would end up holding the last word instead of the first. Requests are also raised with the enable cleared, and a design that ignores the enable would overwrite the zero record. The bench raises both requests in the same cycle, and it sets the enable and raises a request in the same cycle. These catch a design that captures twice or that reads the enable before it has been registered. It reads every selector value after each capture, so a swapped or reversed word order shows as a mismatch.

// File: rtl/crash_snap_pkg.sv
package crash_snap_pkg;
  parameter int unsigned WordW = 32;
  parameter int unsigned SelW  = 2;
  localparam int unsigned CtlW = SelW + 1;

  typedef enum logic [SelW-1:0] {
    SEL_EXC_ADDR  = 2'd0,
    SEL_LAST_DADR = 2'd1,
    SEL_NEXT_PC   = 2'd2,
    SEL_CUR_PC    = 2'd3
  } word_sel_e;

  typedef struct packed {
    logic [WordW-1:0] cur_pc;
    logic [WordW-1:0] next_pc;
    logic [WordW-1:0] last_daddr;
    logic [WordW-1:0] exc_addr;
  } dump_rec_t;
endpackage

// File: rtl/crash_snap_ctl.sv
module crash_snap_ctl
  import crash_snap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [CtlW-1:0] wdata_i,
  output logic            en_o,
  output word_sel_e       sel_o,
  output logic [CtlW-1:0] rdata_o
);
  logic            en_q, en_d;
  logic [SelW-1:0] sel_q, sel_d;

  always_comb begin
    en_d  = en_q;
    sel_d = sel_q;
    if (we_i) begin
      en_d  = wdata_i[0];
      sel_d = wdata_i[CtlW-1:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (we_i) begin
      en_q  <= en_d;
      sel_q <= sel_d;
    end
  end

  assign en_o    = en_q;
  assign sel_o   = word_sel_e'(sel_q);
  assign rdata_o = {sel_q, en_q};
endmodule

// File: rtl/crash_snap_trig.sv
module crash_snap_trig #(
  parameter int unsigned NumReq = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [NumReq-1:0] req_i,
  output logic              fire_o
);
  logic [NumReq-1:0] prev_q;
  logic [NumReq-1:0] rise;

  for (genvar g = 0; g < NumReq; g++) begin : g_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= req_i[g];
    end
    assign rise[g] = req_i[g] & ~prev_q[g];
  end

  assign fire_o = en_i & (|rise);
endmodule

// File: rtl/crash_snap_store.sv
module crash_snap_store
  import crash_snap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  dump_rec_t        dump_i,
  input  word_sel_e        sel_i,
  output dump_rec_t        rec_o,
  output logic [WordW-1:0] rd_data_o
);
  dump_rec_t rec_q, rec_d;

  always_comb begin
    rec_d = rec_q;
    if (fire_i) rec_d = dump_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rec_q <= '0;
    else if (fire_i) rec_q <= rec_d;
  end

  always_comb begin
    unique case (sel_i)
      SEL_CUR_PC:    rd_data_o = rec_q.cur_pc;
      SEL_NEXT_PC:   rd_data_o = rec_q.next_pc;
      SEL_LAST_DADR: rd_data_o = rec_q.last_daddr;
      SEL_EXC_ADDR:  rd_data_o = rec_q.exc_addr;
      default:       rd_data_o = '0;
    endcase
  end

  assign rec_o = rec_q;
endmodule

// File: rtl/crash_snap.sv
module crash_snap
  import crash_snap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [2:0]  ctl_wdata,
  output logic [2:0]  ctl_rdata,
  input  logic        hw_rst_req,
  input  logic        dbg_rst_req,
  input  logic [31:0] dump_cur_pc,
  input  logic [31:0] dump_next_pc,
  input  logic [31:0] dump_last_daddr,
  input  logic [31:0] dump_exc_addr,
  output logic [31:0] rd_data
);
  localparam int unsigned NumReq = 2;

  logic              en_w;
  word_sel_e         sel_w;
  logic              fire_w;
  dump_rec_t         dump_w;
  dump_rec_t         rec_w;
  logic [NumReq-1:0] req_w;

  assign req_w  = {dbg_rst_req, hw_rst_req};
  assign dump_w = '{cur_pc: dump_cur_pc, next_pc: dump_next_pc,
                    last_daddr: dump_last_daddr, exc_addr: dump_exc_addr};

  crash_snap_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (ctl_we),
    .wdata_i (ctl_wdata),
    .en_o    (en_w),
    .sel_o   (sel_w),
    .rdata_o (ctl_rdata)
  );

  crash_snap_trig #(.NumReq(NumReq)) u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_w),
    .req_i  (req_w),
    .fire_o (fire_w)
  );

  crash_snap_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (fire_w),
    .dump_i    (dump_w),
    .sel_i     (sel_w),
    .rec_o     (rec_w),
    .rd_data_o (rd_data)
  );
endmodule

// File: rtl/crash_snap_chk.sv
module crash_snap_chk
  import crash_snap_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_we,
  input logic [2:0]  ctl_wdata,
  input logic [2:0]  ctl_rdata,
  input logic        hw_rst_req,
  input logic        dbg_rst_req,
  input logic [31:0] dump_cur_pc,
  input logic [31:0] dump_exc_addr,
  input logic [31:0] rd_data,
  input logic        fire_w,
  input dump_rec_t   rec_w
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (ctl_rdata == 3'd0 && rec_w == '0));

  a_r2_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl_rdata == $past(ctl_wdata));

  a_r3_sel_cur: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[2:1] == 2'd3 |-> rd_data == rec_w.cur_pc);

  a_r3_sel_exc: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[2:1] == 2'd0 |-> rd_data == rec_w.exc_addr);

  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    fire_w |=> (rec_w.cur_pc == $past(dump_cur_pc) && rec_w.exc_addr == $past(dump_exc_addr)));

  a_r6_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    fire_w |-> (ctl_rdata[0] && (hw_rst_req || dbg_rst_req)));

  a_r7_held_once: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && hw_rst_req && $past(hw_rst_req) && !(dbg_rst_req && !$past(dbg_rst_req))) |-> !fire_w);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_w |=> $stable(rec_w));
endmodule

bind crash_snap crash_snap_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctl_we        (ctl_we),
  .ctl_wdata     (ctl_wdata),
  .ctl_rdata     (ctl_rdata),
  .hw_rst_req    (hw_rst_req),
  .dbg_rst_req   (dbg_rst_req),
  .dump_cur_pc   (dump_cur_pc),
  .dump_exc_addr (dump_exc_addr),
  .rd_data       (rd_data),
  .fire_w        (fire_w),
  .rec_w         (rec_w)
);

// File: tb/sim_crash_snap.sv
module sim_crash_snap;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_we;
  logic [2:0]  ctl_wdata;
  logic [2:0]  ctl_rdata;
  logic        hw_rst_req, dbg_rst_req;
  logic [31:0] d_cur, d_nxt, d_lda, d_exc;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";
  bit done = 1'b0;

  // behavioural reference state
  logic [31:0] m_rec [4];   // index = selector code
  bit          m_en;
  int          m_sel;
  bit          m_hw_prev, m_dbg_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  crash_snap u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .hw_rst_req(hw_rst_req), .dbg_rst_req(dbg_rst_req),
    .dump_cur_pc(d_cur), .dump_next_pc(d_nxt), .dump_last_daddr(d_lda),
    .dump_exc_addr(d_exc), .rd_data(rd_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_rec[i] <= '0;
      m_en <= 1'b0; m_sel <= 0; m_hw_prev <= 1'b0; m_dbg_prev <= 1'b0;
    end else begin
      if (m_en && ((hw_rst_req && !m_hw_prev) || (dbg_rst_req && !m_dbg_prev))) begin
        m_rec[3] <= d_cur; m_rec[2] <= d_nxt; m_rec[1] <= d_lda; m_rec[0] <= d_exc;
      end
      if (ctl_we) begin
        m_en <= ctl_wdata[0];
        m_sel <= int'(ctl_wdata[2:1]);
      end
      m_hw_prev <= hw_rst_req;
      m_dbg_prev <= dbg_rst_req;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk({tag, " ctl"}, {29'd0, ctl_rdata}, {29'd0, m_sel[1:0], m_en});
      chk({tag, " window"}, rd_data, m_rec[m_sel]);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(bit en, int sel);
    ctl_we = 1'b1; ctl_wdata = {sel[1:0], en};
    step();
    ctl_we = 1'b0;
  endtask

  task automatic set_dump(logic [31:0] c, logic [31:0] n, logic [31:0] l, logic [31:0] e);
    d_cur = c; d_nxt = n; d_lda = l; d_exc = e;
  endtask

  task automatic read_all(string req, bit en, logic [31:0] c, logic [31:0] n,
                          logic [31:0] l, logic [31:0] e);
    logic [31:0] exp [4];
    exp[3] = c; exp[2] = n; exp[1] = l; exp[0] = e;
    for (int i = 0; i < 4; i++) begin
      wr_ctl(en, i);
      chk({req, " directed word"}, rd_data, exp[i]);
    end
  endtask

  initial begin
    rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0;
    hw_rst_req = 1'b0; dbg_rst_req = 1'b0;
    set_dump(32'h1111_0001, 32'h1111_0002, 32'h1111_0003, 32'h1111_0004);
    step(3);
    chk("R1 ctl in reset", {29'd0, ctl_rdata}, 32'd0);
    chk("R1 window in reset", rd_data, 32'd0);
    rst_n = 1'b1;
    step();
    chk("R1 ctl after reset", {29'd0, ctl_rdata}, 32'd0);
    tag = "R1";
    read_all("R1", 1'b0, 0, 0, 0, 0);

    // R2: field layout
    tag = "R2";
    wr_ctl(1'b1, 2);
    chk("R2 ctl readback", {29'd0, ctl_rdata}, 32'd5);
    wr_ctl(1'b0, 3);
    chk("R2 ctl readback", {29'd0, ctl_rdata}, 32'd6);

    // R6: request while disabled
    tag = "R6";
    hw_rst_req = 1'b1; step(2); hw_rst_req = 1'b0;
    dbg_rst_req = 1'b1; step(2); dbg_rst_req = 1'b0;
    step();
    read_all("R6", 1'b0, 0, 0, 0, 0);

    // R4 + R7: hardware request held, inputs change meanwhile
    tag = "R4";
    wr_ctl(1'b1, 3);
    set_dump(32'hdead_beef, 32'hbeef_dead, 32'haaaa_aaaa, 32'h5555_5555);
    hw_rst_req = 1'b1;
    step();
    chk("R4 captured current PC", rd_data, 32'hdead_beef);
    tag = "R7";
    set_dump(32'h0bad_0001, 32'h0bad_0002, 32'h0bad_0003, 32'h0bad_0004);
    step(4);
    chk("R7 no recapture while held", rd_data, 32'hdead_beef);
    hw_rst_req = 1'b0;
    step();
    read_all("R3", 1'b1, 32'hdead_beef, 32'hbeef_dead, 32'haaaa_aaaa, 32'h5555_5555);

    // R5: debug request
    tag = "R5";
    set_dump(32'haaaa_cccc, 32'hbbbb_8888, 32'hcccc_4444, 32'hdddd_0000);
    dbg_rst_req = 1'b1;
    step();
    set_dump(32'h0, 32'h444, 32'h888, 32'hccc);
    step(3);
    dbg_rst_req = 1'b0;
    step();
    read_all("R5", 1'b1, 32'haaaa_cccc, 32'hbbbb_8888, 32'hcccc_4444, 32'hdddd_0000);

    // R5: both rise together -> one capture; then R7 second held
    set_dump(32'h0, 32'h444, 32'h888, 32'hccc);
    hw_rst_req = 1'b1; dbg_rst_req = 1'b1;
    step();
    set_dump(32'h7, 32'h7, 32'h7, 32'h7);
    step(2);
    tag = "R7";
    dbg_rst_req = 1'b0; step(2);
    hw_rst_req = 1'b0; step();
    read_all("R5", 1'b1, 32'h0, 32'h444, 32'h888, 32'hccc);

    // R4 timing: enable written in the same cycle the request rises -> no capture yet
    tag = "R4";
    wr_ctl(1'b0, 3);
    ctl_we = 1'b1; ctl_wdata = 3'b111; hw_rst_req = 1'b1;
    step();
    ctl_we = 1'b0;
    chk("R4 enable not yet registered", rd_data, 32'h0);
    step(2); hw_rst_req = 1'b0; step();
    chk("R4 still no capture", rd_data, 32'h0);

    // R8: hold across idle cycles and disabling
    tag = "R8";
    wr_ctl(1'b0, 1);
    step(20);
    read_all("R8", 1'b0, 32'h0, 32'h444, 32'h888, 32'hccc);
    read_all("R8", 1'b1, 32'h0, 32'h444, 32'h888, 32'hccc);

    // R1 again: power-on reset clears the record
    tag = "R1";
    rst_n = 1'b0; step(2); rst_n = 1'b1; step();
    read_all("R1", 1'b0, 0, 0, 0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule